// File: doc/BRIEF.md
# Chip Erase Retry Sequencer

This block runs the programmer side of a whole-chip electrical erase on a 16-bit wide, electrically erasable memory. On a start request it asks for the high erase voltage on the programming supply and on one address line. It then drives a long chip-erase pulse with every address bit low. After the pulse it checks the array word by word, under the raised supply, for the fully erased pattern. A word that is not yet erased costs one retry from a count shared by the whole chip, and another chip-wide pulse follows. Checking then resumes at the word that failed, because the words below it have already passed.

When the last word passes, the block drops the programming supply back to normal. After a settling wait it reads the whole array once more in ordinary read mode. If every word holds all ones, the device passes. If the retry count runs out first, the run ends with an exhausted-retries result and no final read. The analog drivers that turn the level requests into voltages sit outside this block. All timing is given in clock cycles, so a testbench can shrink the 100 ms pulse.

Top module: `erase_seq_top`

## Requirements
- R1: While reset is held, and after it until `start`, the outputs are idle: `ce_n`=1, `oe_n`=1, `vpp_hv`=0, `a9_hv`=0, `addr`=0, `done`=0, `pass`=0, `exhausted`=0.
- R2: A `start` seen while idle raises `vpp_hv` and `a9_hv`. Both chip controls stay high for SETUP_CYC cycles before the first pulse.
- R3: Each erase pulse holds `ce_n` low for exactly PULSE_CYC cycles, with `oe_n`=1, `addr`=0 and both high-voltage requests set.
- R4: After `ce_n` rises at the end of a pulse, `addr` stays 0 and `a9_hv` stays set for HOLD_CYC cycles before verification begins.
- R5: Erase-verify drives `ce_n`=1, `oe_n`=0, `vpp_hv`=1 and `a9_hv`=0. Each address is held RD_CYC cycles, and `rd_data` is taken in the last of them. A word passes only if it equals 16'hFFFF, and a pass moves `addr` up by one.
- R6: A failing verify adds one to a single chip-wide retry count. If the new count is below RETRY_MAX, another pulse follows, and verification restarts at the failing address, not at 0.
- R7: When the count reaches RETRY_MAX, no further pulse is issued. Both requests drop, and `done` pulses with `pass`=0 and `exhausted`=1.
- R8: After the last address passes verify, `vpp_hv` stays low with both controls high for SETUP_CYC cycles. A read with `ce_n`=0 and `oe_n`=0 then walks `addr` from 0 upward, RD_CYC cycles per word.
- R9: If the final read sees all ones at every address, `done` pulses with `pass`=1. The first word that is not 16'hFFFF ends the run with `pass`=0 and `exhausted`=0.
- R10: `done` lasts exactly one cycle. `pass` and `exhausted` hold their value until the next accepted `start`, and a `start` while a run is busy has no effect.
- R11: `a9_hv` is never set without `vpp_hv`, and `ce_n` and `oe_n` are never both low while `vpp_hv` is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| start | input | 1 | Begins an erase run when the block is idle |
| rd_data | input | DATA_W | Word read back from the memory |
| vpp_hv | output | 1 | Request for erase voltage on the programming supply |
| a9_hv | output | 1 | Request for high voltage on the erase-select address line |
| ce_n | output | 1 | Chip enable, active low |
| oe_n | output | 1 | Output enable, active low |
| addr | output | ADDR_W | Word address driven to the memory |
| done | output | 1 | One-cycle end-of-run pulse |
| pass | output | 1 | Device passed; held until the next start |
| exhausted | output | 1 | Retry limit reached; held until the next start |

## Verification
The end of the address scan and a retry can land in the same cycle. This happens when the word that fails verify is the last one, so the decision to pulse again has to win over the move to lowering the supply. The bench provokes this with a memory model in which only the top word needs several pulses. In one case it needs exactly the limit, so the run must pass after resuming at the top address. In the other it needs one more than the limit, so the limit is reached on that same last word. Each case is judged by the pulse count, the resume address, the length of the final read and the two result flags.

// File: rtl/erase_seq_pkg.sv
package erase_seq_pkg;

  typedef enum logic [2:0] {
    ST_IDLE    = 3'd0,
    ST_SETUP   = 3'd1,
    ST_PULSE   = 3'd2,
    ST_HOLD    = 3'd3,
    ST_VERIFY  = 3'd4,
    ST_LOWER   = 3'd5,
    ST_COMPARE = 3'd6,
    ST_DONE    = 3'd7
  } seq_state_t;

  function automatic int unsigned max2(input int unsigned a, input int unsigned b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/erase_seq_timer.sv
module erase_seq_timer #(
  parameter int unsigned W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] load_val,
  output logic         zero
);

  logic [W-1:0] count_q;
  logic [W-1:0] count_d;
  logic         count_en;

  always_comb begin
    count_en = load || (count_q != '0);
    count_d  = load ? load_val : (count_q - 1'b1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        count_q <= '0;
    else if (count_en) count_q <= count_d;
  end

  assign zero = (count_q == '0);

  // R3: an unloaded, non-zero count drops by exactly one per cycle
  a_r3_timer_countdown: assert property (@(posedge clk) disable iff (!rst_n)
    (!load && count_q != '0) |=> (count_q == $past(count_q) - 1'b1));

endmodule

// File: rtl/erase_seq_ptr.sv
module erase_seq_ptr #(
  parameter int unsigned ADDR_W = 18
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clear,
  input  logic              inc,
  output logic [ADDR_W-1:0] ptr,
  output logic              last
);

  logic [ADDR_W-1:0] ptr_q;
  logic [ADDR_W-1:0] ptr_d;
  logic              ptr_en;

  always_comb begin
    ptr_en = clear || inc;
    ptr_d  = clear ? '0 : (ptr_q + 1'b1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      ptr_q <= '0;
    else if (ptr_en) ptr_q <= ptr_d;
  end

  assign ptr  = ptr_q;
  assign last = &ptr_q;

  // R5: a passing word moves the scan up by exactly one
  a_r5_ptr_step: assert property (@(posedge clk) disable iff (!rst_n)
    (inc && !clear) |=> (ptr_q == $past(ptr_q) + 1'b1));

  // R8: the scan restarts from word zero
  a_r8_ptr_clear: assert property (@(posedge clk) disable iff (!rst_n)
    clear |=> (ptr_q == '0));

endmodule

// File: rtl/erase_seq_retry.sv
module erase_seq_retry #(
  parameter int unsigned LIMIT = 20
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clear,
  input  logic inc,
  output logic final_try
);

  localparam int unsigned CNT_W = $clog2(LIMIT + 1);

  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] cnt_d;
  logic             cnt_en;

  always_comb begin
    cnt_en = clear || inc;
    cnt_d  = clear ? '0 : (cnt_q + 1'b1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  assign final_try = (cnt_q == CNT_W'(LIMIT - 1));

  // R6: the shared count never passes its limit
  a_r6_retry_bound: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= CNT_W'(LIMIT));

  // R6: each failed verify adds exactly one
  a_r6_retry_step: assert property (@(posedge clk) disable iff (!rst_n)
    (inc && !clear) |=> (cnt_q == $past(cnt_q) + 1'b1));

endmodule

// File: rtl/erase_seq_top.sv
module erase_seq_top
  import erase_seq_pkg::*;
#(
  parameter int unsigned ADDR_W    = 18,
  parameter int unsigned DATA_W    = 16,
  parameter int unsigned PULSE_CYC = 12_500_000,
  parameter int unsigned SETUP_CYC = 250,
  parameter int unsigned HOLD_CYC  = 250,
  parameter int unsigned RD_CYC    = 4,
  parameter int unsigned RETRY_MAX = 20
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [DATA_W-1:0] rd_data,
  output logic              vpp_hv,
  output logic              a9_hv,
  output logic              ce_n,
  output logic              oe_n,
  output logic [ADDR_W-1:0] addr,
  output logic              done,
  output logic              pass,
  output logic              exhausted
);

  localparam int unsigned T_MAX = max2(max2(PULSE_CYC, SETUP_CYC), max2(HOLD_CYC, RD_CYC));
  localparam int unsigned TMR_W = $clog2(T_MAX + 1) + 1;
  localparam logic [TMR_W-1:0] LD_PULSE = TMR_W'(PULSE_CYC - 1);
  localparam logic [TMR_W-1:0] LD_SETUP = TMR_W'(SETUP_CYC - 1);
  localparam logic [TMR_W-1:0] LD_HOLD  = TMR_W'(HOLD_CYC - 1);
  localparam logic [TMR_W-1:0] LD_RD    = TMR_W'(RD_CYC - 1);

  // reset: asserted at once, released through two flops
  logic [1:0] rst_sync_q;
  logic       rst_int_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end

  assign rst_int_n = rst_sync_q[1];

  seq_state_t        state_q, state_d;
  logic              tmr_load, tmr_zero;
  logic [TMR_W-1:0]  tmr_val;
  logic              ptr_clr, ptr_inc, ptr_last;
  logic [ADDR_W-1:0] ptr;
  logic              rty_clr, rty_inc, rty_final;
  logic              res_clr, set_pass, set_exh, res_en;
  logic              pass_q, exh_q;
  logic              word_ok;

  assign word_ok = (rd_data == {DATA_W{1'b1}});

  erase_seq_timer #(.W(TMR_W)) u_timer (
    .clk      (clk),
    .rst_n    (rst_int_n),
    .load     (tmr_load),
    .load_val (tmr_val),
    .zero     (tmr_zero)
  );

  erase_seq_ptr #(.ADDR_W(ADDR_W)) u_ptr (
    .clk   (clk),
    .rst_n (rst_int_n),
    .clear (ptr_clr),
    .inc   (ptr_inc),
    .ptr   (ptr),
    .last  (ptr_last)
  );

  erase_seq_retry #(.LIMIT(RETRY_MAX)) u_retry (
    .clk       (clk),
    .rst_n     (rst_int_n),
    .clear     (rty_clr),
    .inc       (rty_inc),
    .final_try (rty_final)
  );

  // next-state logic
  always_comb begin
    state_d  = state_q;
    tmr_load = 1'b0;
    tmr_val  = '0;
    ptr_clr  = 1'b0;
    ptr_inc  = 1'b0;
    rty_clr  = 1'b0;
    rty_inc  = 1'b0;
    res_clr  = 1'b0;
    set_pass = 1'b0;
    set_exh  = 1'b0;
    unique case (state_q)
      ST_IDLE: begin
        if (start) begin
          state_d  = ST_SETUP;
          tmr_load = 1'b1;
          tmr_val  = LD_SETUP;
          ptr_clr  = 1'b1;
          rty_clr  = 1'b1;
          res_clr  = 1'b1;
        end
      end
      ST_SETUP: begin
        if (tmr_zero) begin
          state_d  = ST_PULSE;
          tmr_load = 1'b1;
          tmr_val  = LD_PULSE;
        end
      end
      ST_PULSE: begin
        if (tmr_zero) begin
          state_d  = ST_HOLD;
          tmr_load = 1'b1;
          tmr_val  = LD_HOLD;
        end
      end
      ST_HOLD: begin
        if (tmr_zero) begin
          state_d  = ST_VERIFY;
          tmr_load = 1'b1;
          tmr_val  = LD_RD;
        end
      end
      ST_VERIFY: begin
        if (tmr_zero) begin
          if (word_ok) begin
            tmr_load = 1'b1;
            if (ptr_last) begin
              state_d = ST_LOWER;
              tmr_val = LD_SETUP;
              ptr_clr = 1'b1;
            end else begin
              tmr_val = LD_RD;
              ptr_inc = 1'b1;
            end
          end else begin
            rty_inc = 1'b1;
            if (rty_final) begin
              state_d = ST_DONE;
              set_exh = 1'b1;
            end else begin
              state_d  = ST_PULSE;
              tmr_load = 1'b1;
              tmr_val  = LD_PULSE;
            end
          end
        end
      end
      ST_LOWER: begin
        if (tmr_zero) begin
          state_d  = ST_COMPARE;
          tmr_load = 1'b1;
          tmr_val  = LD_RD;
        end
      end
      ST_COMPARE: begin
        if (tmr_zero) begin
          if (!word_ok) begin
            state_d = ST_DONE;
          end else if (ptr_last) begin
            state_d  = ST_DONE;
            set_pass = 1'b1;
          end else begin
            ptr_inc  = 1'b1;
            tmr_load = 1'b1;
            tmr_val  = LD_RD;
          end
        end
      end
      ST_DONE: state_d = ST_IDLE;
      default: state_d = ST_IDLE;
    endcase
  end

  // state register
  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) state_q <= ST_IDLE;
    else            state_q <= state_d;
  end

  // result flags with explicit enable
  assign res_en = res_clr || set_pass || set_exh;

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) begin
      pass_q <= 1'b0;
      exh_q  <= 1'b0;
    end else if (res_en) begin
      pass_q <= set_pass;
      exh_q  <= set_exh;
    end
  end

  // output decode
  always_comb begin
    vpp_hv = 1'b0;
    a9_hv  = 1'b0;
    ce_n   = 1'b1;
    oe_n   = 1'b1;
    addr   = '0;
    done   = 1'b0;
    unique case (state_q)
      ST_SETUP, ST_HOLD: begin
        vpp_hv = 1'b1;
        a9_hv  = 1'b1;
      end
      ST_PULSE: begin
        vpp_hv = 1'b1;
        a9_hv  = 1'b1;
        ce_n   = 1'b0;
      end
      ST_VERIFY: begin
        vpp_hv = 1'b1;
        oe_n   = 1'b0;
        addr   = ptr;
      end
      ST_COMPARE: begin
        ce_n = 1'b0;
        oe_n = 1'b0;
        addr = ptr;
      end
      ST_DONE: done = 1'b1;
      default: ;
    endcase
  end

  assign pass      = pass_q;
  assign exhausted = exh_q;

  // checker: window of HOLD_CYC cycles after each pulse ends
  localparam int unsigned HW = $clog2(HOLD_CYC + 1) + 1;
  logic          ce_n_d;
  logic          a9_d;
  logic [HW-1:0] hold_left_q;
  logic          pulse_end;
  logic          hold_win;

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) begin
      ce_n_d <= 1'b1;
      a9_d   <= 1'b0;
    end else begin
      ce_n_d <= ce_n;
      a9_d   <= a9_hv;
    end
  end

  assign pulse_end = ce_n && !ce_n_d && a9_d;
  assign hold_win  = pulse_end || (hold_left_q != '0);

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n)              hold_left_q <= '0;
    else if (pulse_end)          hold_left_q <= HW'(HOLD_CYC - 1);
    else if (hold_left_q != '0)  hold_left_q <= hold_left_q - 1'b1;
  end

  // R4: address parked at zero, chip idle, erase select high
  a_r4_hold_window: assert property (@(posedge clk) disable iff (!rst_int_n)
    hold_win |-> (addr == '0 && ce_n && oe_n && a9_hv));

  // R3: every pulse cycle drives word zero with outputs disabled
  a_r3_pulse_addr_zero: assert property (@(posedge clk) disable iff (!rst_int_n)
    (!ce_n && a9_hv) |-> (addr == '0 && oe_n && vpp_hv));

  // R11: erase select only under raised supply
  a_r11_a9_with_vpp: assert property (@(posedge clk) disable iff (!rst_int_n)
    a9_hv |-> vpp_hv);

  // R11: no normal read while supply is raised
  a_r11_no_read_at_hv: assert property (@(posedge clk) disable iff (!rst_int_n)
    vpp_hv |-> (ce_n || oe_n));

  // R10: done is a single-cycle pulse
  a_r10_done_single: assert property (@(posedge clk) disable iff (!rst_int_n)
    done |=> !done);

  // R7: the two verdicts never stand together
  a_r7_verdict_exclusive: assert property (@(posedge clk) disable iff (!rst_int_n)
    !(pass && exhausted));

  // R10: flags change only with a new run or at its end
  a_r10_flags_stable: assert property (@(posedge clk) disable iff (!rst_int_n)
    (!res_en) |=> ($stable(pass) && $stable(exhausted)));

endmodule

// File: tb/erase_seq_top_tb.sv
module erase_seq_top_tb;

  localparam int unsigned ADDR_W = 3;
  localparam int unsigned WORDS  = 1 << ADDR_W;
  localparam int unsigned PULSE  = 40;
  localparam int unsigned SETUP  = 8;
  localparam int unsigned HOLD   = 6;
  localparam int unsigned RD     = 2;
  localparam int unsigned RMAX   = 4;
  localparam int unsigned NVEC   = 7;

  // layout: need[54:23] (4 bits per word, word 0 lowest), bad_en[22],
  // bad_addr[21:19], poke[18], exp_pass[17], exp_exh[16], exp_pulses[15:12],
  // exp_resume[11:8] (F = no second pulse), exp_cmp_cycles[7:0]
  localparam logic [54:0] VEC [NVEC] = '{
    {32'h1111_1111, 1'b0, 3'd0, 1'b0, 1'b1, 1'b0, 4'd1, 4'hF, 8'd16},
    {32'h1111_3111, 1'b0, 3'd0, 1'b1, 1'b1, 1'b0, 4'd3, 4'd3, 8'd16},
    {32'h4111_1112, 1'b0, 3'd0, 1'b0, 1'b1, 1'b0, 4'd4, 4'd0, 8'd16},
    {32'h5111_1111, 1'b0, 3'd0, 1'b0, 1'b0, 1'b1, 4'd4, 4'd7, 8'd0},
    {32'h1111_1111, 1'b1, 3'd6, 1'b0, 1'b0, 1'b0, 4'd1, 4'hF, 8'd14},
    {32'h1113_1211, 1'b0, 3'd0, 1'b0, 1'b1, 1'b0, 4'd3, 4'd2, 8'd16},
    {32'h4111_1111, 1'b0, 3'd0, 1'b0, 1'b1, 1'b0, 4'd4, 4'd7, 8'd16}
  };

  logic              clk;
  logic              rst_n;
  logic              start;
  logic [15:0]       rd_data;
  logic              vpp_hv, a9_hv, ce_n, oe_n, done, pass, exhausted;
  logic [ADDR_W-1:0] addr;

  erase_seq_top #(
    .ADDR_W(ADDR_W), .DATA_W(16), .PULSE_CYC(PULSE), .SETUP_CYC(SETUP),
    .HOLD_CYC(HOLD), .RD_CYC(RD), .RETRY_MAX(RMAX)
  ) u_dut (
    .clk(clk), .rst_n(rst_n), .start(start), .rd_data(rd_data),
    .vpp_hv(vpp_hv), .a9_hv(a9_hv), .ce_n(ce_n), .oe_n(oe_n),
    .addr(addr), .done(done), .pass(pass), .exhausted(exhausted)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  int n_checks = 0;
  int n_fail   = 0;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // memory model and monitor state
  logic [31:0]       cur_need;
  logic              bad_en;
  logic [ADDR_W-1:0] bad_addr;
  logic              mon_clr;
  int pulses, pw, bad_pw, hold_cnt, bad_hold, ver_entries, resume_addr;
  int vrun, bad_run, setup_cnt, setup_len, low_cnt, lower_len, cmp_cnt, bad_coh;
  bit in_hold, in_setup, in_low;
  logic prev_ce, prev_oe, prev_vpp, prev_a9, prev_done;
  logic [ADDR_W-1:0] prev_addr;

  always_comb begin
    if (!vpp_hv && bad_en && addr == bad_addr)
      rd_data = 16'hFFFE;
    else if (pulses >= int'(cur_need[addr*4 +: 4]))
      rd_data = 16'hFFFF;
    else
      rd_data = 16'h0F0F;
  end

  always @(negedge clk) begin
    if (mon_clr) begin
      pulses = 0; pw = 0; bad_pw = 0; hold_cnt = 0; bad_hold = 0;
      ver_entries = 0; resume_addr = 15; vrun = 0; bad_run = 0;
      setup_cnt = 0; setup_len = -1; low_cnt = 0; lower_len = -1;
      cmp_cnt = 0; bad_coh = 0; in_hold = 0; in_setup = 0; in_low = 0;
    end else begin
      if ((a9_hv && !vpp_hv) || (vpp_hv && !ce_n && !oe_n)) bad_coh++;
      // pulses
      if (!ce_n && prev_ce && a9_hv) begin
        pulses++; pw = 1;
      end else if (!ce_n && a9_hv) pw++;
      // hold after pulse
      if (ce_n && !prev_ce && prev_a9) begin
        if (pw != PULSE) bad_pw++;
        in_hold = 1; hold_cnt = 1;
        if (addr != 0 || !a9_hv) bad_hold++;
      end else if (in_hold && ce_n && oe_n) begin
        hold_cnt++;
        if (addr != 0 || !a9_hv) bad_hold++;
      end
      // verify runs
      if (!oe_n && prev_oe && vpp_hv) begin
        if (in_hold && hold_cnt != HOLD) bad_hold++;
        in_hold = 0;
        ver_entries++;
        if (ver_entries == 2) resume_addr = int'(addr);
        vrun = 1;
      end else if (!oe_n && vpp_hv) begin
        if (addr != prev_addr) begin
          if (vrun != RD) bad_run++;
          vrun = 1;
        end else vrun++;
      end else if (oe_n && !prev_oe && prev_vpp) begin
        if (vrun != RD) bad_run++;
      end
      // setup before first pulse
      if (vpp_hv && !prev_vpp) begin
        in_setup = 1; setup_cnt = 1;
      end else if (in_setup) begin
        if (!ce_n) begin
          in_setup = 0; setup_len = setup_cnt;
        end else setup_cnt++;
      end
      // supply lowering before final read
      if (!vpp_hv && prev_vpp && !done) begin
        in_low = 1; low_cnt = 1;
      end else if (in_low) begin
        if (!ce_n) begin
          in_low = 0; lower_len = low_cnt;
        end else low_cnt++;
      end
      if (!ce_n && !oe_n) cmp_cnt++;
    end
    prev_ce = ce_n; prev_oe = oe_n; prev_vpp = vpp_hv; prev_a9 = a9_hv;
    prev_addr = addr; prev_done = done;
  end

  task automatic clear_mon();
    mon_clr = 1'b1;
    @(negedge clk);
    #1 mon_clr = 1'b0;
  endtask

  task automatic run_vec(input int idx);
    logic [54:0] v;
    bit got_done;
    bit exp_pass, exp_exh;
    int exp_pulses, exp_resume, exp_cmp;
    v          = VEC[idx];
    cur_need   = v[54:23];
    bad_en     = v[22];
    bad_addr   = v[21:19];
    exp_pass   = v[17];
    exp_exh    = v[16];
    exp_pulses = int'(v[15:12]);
    exp_resume = int'(v[11:8]);
    exp_cmp    = int'(v[7:0]);
    clear_mon();
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    got_done = 0;
    for (int c = 0; c < 20000; c++) begin
      @(negedge clk);
      if (v[18] && c == 100) start = 1'b1;
      else start = 1'b0;
      if (done) begin
        got_done = 1;
        break;
      end
    end
    start = 1'b0;
    chk(got_done, $sformatf("R10 run %0d reached done (watchdog)", idx), got_done, 1);
    if (!got_done) return;
    chk(pass == exp_pass, $sformatf("R9 run %0d pass", idx), pass, exp_pass);
    chk(exhausted == exp_exh, $sformatf("R7 run %0d exhausted", idx), exhausted, exp_exh);
    chk(pulses == exp_pulses, $sformatf("R6 run %0d pulse count", idx), pulses, exp_pulses);
    chk(resume_addr == exp_resume, $sformatf("R6 run %0d resume address", idx), resume_addr, exp_resume);
    chk(bad_pw == 0, $sformatf("R3 run %0d pulse width", idx), bad_pw, 0);
    chk(bad_hold == 0, $sformatf("R4 run %0d hold after pulse", idx), bad_hold, 0);
    chk(setup_len == SETUP, $sformatf("R2 run %0d setup length", idx), setup_len, SETUP);
    chk(bad_run == 0, $sformatf("R5 run %0d verify word timing", idx), bad_run, 0);
    chk(cmp_cnt == exp_cmp, $sformatf("R8 run %0d final read cycles", idx), cmp_cnt, exp_cmp);
    if (!exp_exh)
      chk(lower_len == SETUP, $sformatf("R8 run %0d lowering length", idx), lower_len, SETUP);
    chk(bad_coh == 0, $sformatf("R11 run %0d voltage/control coherence", idx), bad_coh, 0);
    @(negedge clk);
    chk(!done, $sformatf("R10 run %0d done single cycle", idx), done, 0);
    chk(pass == exp_pass && exhausted == exp_exh,
        $sformatf("R10 run %0d flags held", idx), {pass, exhausted}, {exp_pass, exp_exh});
    chk(ce_n && oe_n && !vpp_hv && !a9_hv, $sformatf("R1 run %0d idle after done", idx),
        {ce_n, oe_n, vpp_hv, a9_hv}, 4'b1100);
  endtask

  initial begin
    rst_n    = 1'b0;
    start    = 1'b0;
    cur_need = 32'h1111_1111;
    bad_en   = 1'b0;
    bad_addr = '0;
    mon_clr  = 1'b1;
    repeat (3) @(negedge clk);
    chk(ce_n && oe_n && !vpp_hv && !a9_hv && addr == 0, "R1 outputs idle in reset",
        {ce_n, oe_n, vpp_hv, a9_hv}, 4'b1100);
    chk(!done && !pass && !exhausted, "R1 flags low in reset", {done, pass, exhausted}, 0);
    rst_n = 1'b1;
    repeat (6) @(negedge clk);
    chk(ce_n && oe_n && !vpp_hv && !a9_hv && addr == 0 && !done, "R1 idle after reset release",
        {ce_n, oe_n, vpp_hv, a9_hv}, 4'b1100);
    mon_clr = 1'b0;

    for (int i = 0; i < NVEC; i++) run_vec(i);

    // reset in the middle of a pulse returns everything to idle (R1)
    cur_need = 32'h1111_1111;
    bad_en   = 1'b0;
    start    = 1'b1;
    @(negedge clk);
    start = 1'b0;
    repeat (SETUP + 10) @(negedge clk);
    chk(!ce_n && a9_hv, "R3 pulse active before reset", {ce_n, a9_hv}, 2'b01);
    rst_n = 1'b0;
    @(negedge clk);
    chk(ce_n && oe_n && !vpp_hv && !a9_hv && addr == 0 && !pass && !exhausted,
        "R1 reset during pulse", {ce_n, oe_n, vpp_hv, a9_hv}, 4'b1100);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // an extra run after reset still passes (R9)
    run_vec(0);

    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

endmodule